// File: doc/BRIEF.md
# Port control microsequencer

This block is a small instruction engine that drives the register interface of a PC-style parallel port without a processor in the loop. A host loads 32-bit microinstructions into a local instruction memory and then pulses `start` with an entry address. The engine then runs on its own through register writes, read-modify-writes, fetches into a local scratch buffer, microsecond delays, counted loops and status-conditional branches. It also supports one level of subsequence call. It stops on a return instruction and shows the return code, or it stops with an error flag on an opcode it does not implement.

The engine keeps a program counter, an 8-bit branch/loop register, a scratch pointer, and a single return address with an "inside subsequence" flag. The port side consists of a latched data register and a latched control register, both driven out. It also takes two inputs: the data lines, which are read back when the data register is fetched, and the status lines. The microsecond time base is the system clock divided by the parameter `US_DIV`.

The control FSM has these states:
- **IDLE**: after reset.
- **EXEC**: one instruction per cycle.
- **WAIT**: a DELAY is running.
- **BLOCK**: a counted byte move is running.
- **TRIG**: a value/delay pair is issued.
- **TRIG_WAIT**: the delay of the current pair is running.
- **DONE**: halted after a return.
- **ERROR**: halted on a fault.

The transitions are:
- IDLE, DONE or ERROR go to EXEC on `start`.
- EXEC goes to WAIT on DELAY, to BLOCK on a block move, to TRIG on TRIG, to DONE on RET, and to ERROR on a fault.
- WAIT goes back to EXEC when the timer expires.
- BLOCK goes back to EXEC when its count is zero.
- TRIG goes to TRIG_WAIT while pairs remain, and to EXEC when none remain.
- TRIG_WAIT goes back to TRIG when the timer expires.

Top module: `mseq_engine`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and `pp_data_o` and `pp_ctrl_o` are 0x00.
- R2: The instruction word has these fields: bits 31:30 are the register select (0 = data, 1 = status, 2 = control, 3 = none), bits 28:24 are the opcode, and bits 23:16, 15:8 and 7:0 are fields A, B and C. A `start` pulse while not busy begins execution at `start_pc`. A lone RET at the entry address raises `done` two cycles after the cycle in which `start` was sampled.
- R3: RASSERT (opcode 4) loads A into the selected register. Writes to select 1 or 3 change neither port output.
- R4: RSET (opcode 3) sets the bits of A and clears the bits of B in the latched register. When both masks hold a bit, the clear wins.
- R5: RFETCH (opcode 2) stores (selected value AND A) into scratch byte C. The data select reads `pp_data_i`, the status select reads `pp_status_i`, and the control select reads the control latch.
- R6: SET (opcode 6) loads A into the branch register. DBRA (opcode 7) decrements it and branches while the result is positive as a signed byte. A body that SET n then loops over runs n times for n ≥ 1, and once for n = 0.
- R7: BRSET (opcode 8) branches if any status bit in A is 1. BRCLEAR (opcode 9) branches if any status bit in A is 0. The target is the address after the branch plus the signed offset in C.
- R8: BRSTAT (opcode 14) branches only if every status bit in A is 1 and every status bit in B is 0, with the target formed as in R7.
- R9: DELAY (opcode 5) stalls for {A,B} microseconds of `US_DIV` clocks each. It adds {A,B}·US_DIV + 2 cycles to the run.
- R10: RET (opcode 10) halts with `done` high and `ret_code` = A. Both hold until the next `start`.
- R11: CALL (opcode 16) jumps to address A and records the next address. SUBRET (opcode 15) returns there. A CALL inside a subsequence, or a SUBRET outside one, halts with `err`.
- R12: Any opcode other than those named in R3 to R14 halts with `err` high. No later instruction takes effect, and the port outputs stay unchanged.
- R13: PTR (opcode 12) loads the scratch pointer from A. RASSERT_P (opcode 17) writes A scratch bytes from the pointer into the selected register. RFETCH_P (opcode 18) stores A fetches ANDed with B at the pointer. Both advance the pointer by one per byte, and a count of 0 moves nothing.
- R14: TRIG (opcode 19) issues A pairs from scratch at the pointer. For each pair it writes the first byte to the selected register and waits the second byte in microseconds, and the pointer advances by two per pair. With US_DIV = 4, the pairs (x,2),(y,0) take 14 cycles and leave y in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| im_we | input | 1 | Instruction memory write strobe |
| im_waddr | input | IAW | Instruction memory write address |
| im_wdata | input | 32 | Instruction word |
| scr_we | input | 1 | Host scratch write strobe (engine writes take priority) |
| scr_waddr | input | BAW | Host scratch write address |
| scr_wdata | input | 8 | Host scratch write byte |
| scr_raddr | input | BAW | Host scratch read address |
| scr_rdata | output | 8 | Scratch byte at `scr_raddr` |
| start | input | 1 | Begin execution when not busy |
| start_pc | input | IAW | Entry address |
| pp_data_i | input | 8 | Parallel port data lines |
| pp_status_i | input | 8 | Parallel port status lines |
| pp_data_o | output | 8 | Latched data register |
| pp_ctrl_o | output | 8 | Latched control register |
| busy | output | 1 | Sequence running |
| done | output | 1 | Halted on RET |
| err | output | 1 | Halted on a fault |
| ret_code | output | 8 | Code from the last RET |

## Verification
Most internal faults surface as a wrong `ret_code` or a wrong halt flag within a few cycles. A corrupted program counter or branch decision takes a different RET, and the test programs give every path its own code. A wrong branch-register or pointer update shows up in the scratch bytes read after the run, as a body that ran too often or bytes written at the wrong place. A wrong prescaler or timer shows up only in the start-to-done latency, as an error in multiples of `US_DIV`, so each timed program is measured to the exact cycle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int BYTE_W = 8;
    localparam int INSN_W = 32;

    // opcode values
    localparam logic [4:0] OP_RFETCH   = 5'd2;
    localparam logic [4:0] OP_RSET     = 5'd3;
    localparam logic [4:0] OP_RASSERT  = 5'd4;
    localparam logic [4:0] OP_DELAY    = 5'd5;
    localparam logic [4:0] OP_SET      = 5'd6;
    localparam logic [4:0] OP_DBRA     = 5'd7;
    localparam logic [4:0] OP_BRSET    = 5'd8;
    localparam logic [4:0] OP_BRCLEAR  = 5'd9;
    localparam logic [4:0] OP_RET      = 5'd10;
    localparam logic [4:0] OP_PTR      = 5'd12;
    localparam logic [4:0] OP_BRSTAT   = 5'd14;
    localparam logic [4:0] OP_SUBRET   = 5'd15;
    localparam logic [4:0] OP_CALL     = 5'd16;
    localparam logic [4:0] OP_RASSERTP = 5'd17;
    localparam logic [4:0] OP_RFETCHP  = 5'd18;
    localparam logic [4:0] OP_TRIG     = 5'd19;

    // register selects
    localparam logic [1:0] RSEL_DATA = 2'd0;
    localparam logic [1:0] RSEL_STAT = 2'd1;
    localparam logic [1:0] RSEL_CTRL = 2'd2;

    typedef struct packed {
        logic [1:0]        rsel;
        logic              spare;
        logic [4:0]        op;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [BYTE_W-1:0] c;
    } insn_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EXEC,
        S_WAIT,
        S_BLOCK,
        S_TRIG,
        S_TRIG_WAIT,
        S_DONE,
        S_ERROR
    } state_e;

endpackage

// File: rtl/mseq_us_timer.sv
module mseq_us_timer #(
    parameter int US_DIV = 50,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_us,
    output logic             expired
);
    localparam int PRE_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] us_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (load) begin
            pre_q <= '0;
            us_q  <= load_us;
        end else if (us_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                us_q  <= us_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (us_q == '0);
endmodule

// File: rtl/mseq_cond.sv
module mseq_cond
    import mseq_pkg::*;
#(
    parameter int PCW = 6
) (
    input  logic [4:0]        op,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] mask_a,
    input  logic [BYTE_W-1:0] mask_b,
    input  logic [BYTE_W-1:0] offset,
    input  logic [BYTE_W-1:0] br_cur,
    input  logic [PCW-1:0]    pc_cur,
    output logic [BYTE_W-1:0] br_dec,
    output logic [PCW-1:0]    pc_seq,
    output logic [PCW-1:0]    pc_tgt,
    output logic              take
);
    logic any_set, any_clear, all_match;

    assign br_dec    = br_cur - 1'b1;
    assign pc_seq    = pc_cur + 1'b1;
    assign pc_tgt    = pc_seq + PCW'($signed(offset));
    assign any_set   = |(status & mask_a);
    assign any_clear = |(~status & mask_a);
    assign all_match = ((status & mask_a) == mask_a) && ((status & mask_b) == '0);

    always_comb begin
        unique case (op)
            OP_DBRA:    take = ($signed(br_dec) > 0);
            OP_BRSET:   take = any_set;
            OP_BRCLEAR: take = any_clear;
            OP_BRSTAT:  take = all_match;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_portregs.sv
module mseq_portregs
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] data_lines,
    input  logic [BYTE_W-1:0] status_lines,
    output logic [BYTE_W-1:0] fetch_val,
    output logic [BYTE_W-1:0] latch_val,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] ctrl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            if (sel == RSEL_DATA) data_q <= wdata;
            if (sel == RSEL_CTRL) ctrl_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            RSEL_DATA: fetch_val = data_lines;
            RSEL_STAT: fetch_val = status_lines;
            RSEL_CTRL: fetch_val = ctrl_q;
            default:   fetch_val = '0;
        endcase
    end

    always_comb begin
        unique case (sel)
            RSEL_DATA: latch_val = data_q;
            RSEL_CTRL: latch_val = ctrl_q;
            default:   latch_val = '0;
        endcase
    end
endmodule

// File: rtl/mseq_engine.sv
module mseq_engine
    import mseq_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int SCR_DEPTH  = 32,
    parameter int US_DIV     = 50,
    parameter int DLY_W      = 16,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int BAW = $clog2(SCR_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              im_we,
    input  logic [IAW-1:0]    im_waddr,
    input  logic [INSN_W-1:0] im_wdata,
    input  logic              scr_we,
    input  logic [BAW-1:0]    scr_waddr,
    input  logic [BYTE_W-1:0] scr_wdata,
    input  logic [BAW-1:0]    scr_raddr,
    output logic [BYTE_W-1:0] scr_rdata,
    input  logic              start,
    input  logic [IAW-1:0]    start_pc,
    input  logic [BYTE_W-1:0] pp_data_i,
    input  logic [BYTE_W-1:0] pp_status_i,
    output logic [BYTE_W-1:0] pp_data_o,
    output logic [BYTE_W-1:0] pp_ctrl_o,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] ret_code
);
    // storage
    logic [INSN_W-1:0] imem [IMEM_DEPTH];
    logic [BYTE_W-1:0] scr  [SCR_DEPTH];

    // context
    state_e            state_q, state_d;
    logic [IAW-1:0]    pc_q, pc_d, rpc_q, rpc_d;
    logic [BYTE_W-1:0] br_q, br_d, cnt_q, cnt_d, ret_q, ret_d;
    logic [BAW-1:0]    ptr_q, ptr_d;
    logic              sub_q, sub_d;
    logic [1:0]        bsel_q, bsel_d;
    logic              bfetch_q, bfetch_d;
    logic [BYTE_W-1:0] bmask_q, bmask_d;

    // control strobes
    logic              reg_we;
    logic [1:0]        reg_sel;
    logic [BYTE_W-1:0] reg_wdata;
    logic              eng_wr;
    logic [BAW-1:0]    eng_addr;
    logic [BYTE_W-1:0] eng_data;
    logic              tmr_load, tmr_exp;
    logic [DLY_W-1:0]  tmr_val;

    insn_t             ins;
    logic [BYTE_W-1:0] fetch_val, latch_val, br_dec, scr_at_ptr, scr_at_ptr1;
    logic [IAW-1:0]    pc_seq, pc_tgt;
    logic              take;
    logic              unused_bits;

    assign ins         = insn_t'(imem[pc_q]);
    assign scr_at_ptr  = scr[ptr_q];
    assign scr_at_ptr1 = scr[ptr_q + 1'b1];
    assign scr_rdata   = scr[scr_raddr];
    assign reg_sel     = (state_q == S_EXEC) ? ins.rsel : bsel_q;
    assign unused_bits = ins.spare;

    mseq_cond #(.PCW(IAW)) u_cond (
        .op     (ins.op),
        .status (pp_status_i),
        .mask_a (ins.a),
        .mask_b (ins.b),
        .offset (ins.c),
        .br_cur (br_q),
        .pc_cur (pc_q),
        .br_dec (br_dec),
        .pc_seq (pc_seq),
        .pc_tgt (pc_tgt),
        .take   (take)
    );

    mseq_portregs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (reg_we),
        .sel          (reg_sel),
        .wdata        (reg_wdata),
        .data_lines   (pp_data_i),
        .status_lines (pp_status_i),
        .fetch_val    (fetch_val),
        .latch_val    (latch_val),
        .data_q       (pp_data_o),
        .ctrl_q       (pp_ctrl_o)
    );

    mseq_us_timer #(.US_DIV(US_DIV), .CNT_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_us (tmr_val),
        .expired (tmr_exp)
    );

    // memory writes
    always_ff @(posedge clk) begin
        if (im_we) imem[im_waddr] <= im_wdata;
    end

    always_ff @(posedge clk) begin
        if (eng_wr)      scr[eng_addr]  <= eng_data;
        else if (scr_we) scr[scr_waddr] <= scr_wdata;
    end

    // next state and datapath control
    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        rpc_d     = rpc_q;
        br_d      = br_q;
        cnt_d     = cnt_q;
        ret_d     = ret_q;
        ptr_d     = ptr_q;
        sub_d     = sub_q;
        bsel_d    = bsel_q;
        bfetch_d  = bfetch_q;
        bmask_d   = bmask_q;
        reg_we    = 1'b0;
        reg_wdata = ins.a;
        eng_wr    = 1'b0;
        eng_addr  = BAW'(ins.c);
        eng_data  = fetch_val & ins.a;
        tmr_load  = 1'b0;
        tmr_val   = DLY_W'({ins.a, ins.b});

        unique case (state_q)
            S_IDLE, S_DONE, S_ERROR: begin
                if (start) begin
                    state_d = S_EXEC;
                    pc_d    = start_pc;
                    br_d    = '0;
                    ptr_d   = '0;
                    sub_d   = 1'b0;
                end
            end

            S_EXEC: begin
                pc_d = pc_seq;
                unique case (ins.op)
                    OP_RFETCH:  eng_wr = 1'b1;
                    OP_RSET: begin
                        reg_we    = 1'b1;
                        reg_wdata = (latch_val | ins.a) & ~ins.b;
                    end
                    OP_RASSERT: reg_we = 1'b1;
                    OP_DELAY: begin
                        tmr_load = 1'b1;
                        state_d  = S_WAIT;
                    end
                    OP_SET:     br_d = ins.a;
                    OP_DBRA: begin
                        br_d = br_dec;
                        if (take) pc_d = pc_tgt;
                    end
                    OP_BRSET, OP_BRCLEAR, OP_BRSTAT: begin
                        if (take) pc_d = pc_tgt;
                    end
                    OP_RET: begin
                        ret_d   = ins.a;
                        state_d = S_DONE;
                    end
                    OP_PTR:     ptr_d = BAW'(ins.a);
                    OP_SUBRET: begin
                        if (sub_q) begin
                            pc_d  = rpc_q;
                            sub_d = 1'b0;
                        end else begin
                            state_d = S_ERROR;
                        end
                    end
                    OP_CALL: begin
                        if (!sub_q) begin
                            rpc_d = pc_seq;
                            pc_d  = IAW'(ins.a);
                            sub_d = 1'b1;
                        end else begin
                            state_d = S_ERROR;
                        end
                    end
                    OP_RASSERTP, OP_RFETCHP: begin
                        bsel_d   = ins.rsel;
                        bfetch_d = (ins.op == OP_RFETCHP);
                        bmask_d  = ins.b;
                        cnt_d    = ins.a;
                        state_d  = S_BLOCK;
                    end
                    OP_TRIG: begin
                        bsel_d  = ins.rsel;
                        cnt_d   = ins.a;
                        state_d = S_TRIG;
                    end
                    default:    state_d = S_ERROR;
                endcase
            end

            S_WAIT: begin
                if (tmr_exp) state_d = S_EXEC;
            end

            S_BLOCK: begin
                if (cnt_q == '0) begin
                    state_d = S_EXEC;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                    ptr_d = ptr_q + 1'b1;
                    if (bfetch_q) begin
                        eng_wr   = 1'b1;
                        eng_addr = ptr_q;
                        eng_data = fetch_val & bmask_q;
                    end else begin
                        reg_we    = 1'b1;
                        reg_wdata = scr_at_ptr;
                    end
                end
            end

            S_TRIG: begin
                if (cnt_q == '0) begin
                    state_d = S_EXEC;
                end else begin
                    reg_we    = 1'b1;
                    reg_wdata = scr_at_ptr;
                    tmr_load  = 1'b1;
                    tmr_val   = DLY_W'(scr_at_ptr1);
                    ptr_d     = ptr_q + BAW'(2);
                    cnt_d     = cnt_q - 1'b1;
                    state_d   = S_TRIG_WAIT;
                end
            end

            S_TRIG_WAIT: begin
                if (tmr_exp) state_d = S_TRIG;
            end

            default: state_d = S_ERROR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // execution context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            rpc_q    <= '0;
            br_q     <= '0;
            cnt_q    <= '0;
            ret_q    <= '0;
            ptr_q    <= '0;
            sub_q    <= 1'b0;
            bsel_q   <= '0;
            bfetch_q <= 1'b0;
            bmask_q  <= '0;
        end else begin
            pc_q     <= pc_d;
            rpc_q    <= rpc_d;
            br_q     <= br_d;
            cnt_q    <= cnt_d;
            ret_q    <= ret_d;
            ptr_q    <= ptr_d;
            sub_q    <= sub_d;
            bsel_q   <= bsel_d;
            bfetch_q <= bfetch_d;
            bmask_q  <= bmask_d;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        ret_code = ret_q;
        unique case (state_q)
            S_EXEC, S_WAIT, S_BLOCK, S_TRIG, S_TRIG_WAIT: busy = 1'b1;
            S_DONE:  done = 1'b1;
            S_ERROR: err  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mseq_engine_chk.sv
module mseq_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [7:0] ret_code,
    input logic [7:0] pp_data_o,
    input logic [7:0] pp_ctrl_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !done && !err && pp_data_o == 8'h00 && pp_ctrl_o == 8'h00));

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, err}));

    p_ret_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(ret_code)));

    p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && !busy));

    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err) && !start) |=> ($stable(pp_data_o) && $stable(pp_ctrl_o)));
endmodule

bind mseq_engine mseq_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .ret_code  (ret_code),
    .pp_data_o (pp_data_o),
    .pp_ctrl_o (pp_ctrl_o)
);

// File: tb/mseq_engine_bench.sv
module mseq_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NVEC       = 11;

    // {status, expected return code} for the branch program at address 0
    localparam logic [15:0] VEC [NVEC] = '{
        {8'hC0, 8'h01}, {8'hD0, 8'h01}, {8'hD1, 8'h01}, {8'hC8, 8'h03},
        {8'h40, 8'h03}, {8'h18, 8'h03}, {8'h60, 8'h02}, {8'h02, 8'h02},
        {8'hFF, 8'h02}, {8'h11, 8'h0F}, {8'h91, 8'h0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        im_we = 1'b0;
    logic [5:0]  im_waddr = '0;
    logic [31:0] im_wdata = '0;
    logic        scr_we = 1'b0;
    logic [4:0]  scr_waddr = '0;
    logic [7:0]  scr_wdata = '0;
    logic [4:0]  scr_raddr = '0;
    logic [7:0]  scr_rdata;
    logic        start = 1'b0;
    logic [5:0]  start_pc = '0;
    logic [7:0]  pp_data_i = '0;
    logic [7:0]  pp_status_i = '0;
    logic [7:0]  pp_data_o, pp_ctrl_o, ret_code;
    logic        busy, done, err;

    int checks = 0;
    int errors = 0;
    int lat;
    logic [7:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    mseq_engine #(.IMEM_DEPTH(64), .SCR_DEPTH(32), .US_DIV(DIV)) u_mseq_engine (
        .clk(clk), .rst_n(rst_n),
        .im_we(im_we), .im_waddr(im_waddr), .im_wdata(im_wdata),
        .scr_we(scr_we), .scr_waddr(scr_waddr), .scr_wdata(scr_wdata),
        .scr_raddr(scr_raddr), .scr_rdata(scr_rdata),
        .start(start), .start_pc(start_pc),
        .pp_data_i(pp_data_i), .pp_status_i(pp_status_i),
        .pp_data_o(pp_data_o), .pp_ctrl_o(pp_ctrl_o),
        .busy(busy), .done(done), .err(err), .ret_code(ret_code)
    );

    function automatic logic [31:0] mk(input logic [1:0] rs, input logic [4:0] op,
                                       input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] c);
        return {rs, 1'b0, op, a, b, c};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wi(input int addr, input logic [31:0] w);
        @(negedge clk);
        im_we = 1'b1; im_waddr = 6'(addr); im_wdata = w;
        @(negedge clk);
        im_we = 1'b0;
    endtask

    task automatic ws(input int addr, input logic [7:0] v);
        @(negedge clk);
        scr_we = 1'b1; scr_waddr = 5'(addr); scr_wdata = v;
        @(negedge clk);
        scr_we = 1'b0;
    endtask

    task automatic rs(input int addr, output logic [7:0] v);
        @(negedge clk);
        scr_raddr = 5'(addr);
        #1 v = scr_rdata;
    endtask

    task automatic run(input int pc, output int cycles);
        @(negedge clk);
        start = 1'b1; start_pc = 6'(pc);
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && !err && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 data out", pp_data_o, 8'h00);
        chk("R1 ctrl out", pp_ctrl_o, 8'h00);

        // branch program
        wi(0, mk(0, 5'd14, 8'hC0, 8'h08, 8'd3));
        wi(1, mk(0, 5'd8, 8'h22, 8'h00, 8'd3));
        wi(2, mk(0, 5'd9, 8'h11, 8'h00, 8'd3));
        wi(3, mk(0, 5'd10, 8'h0F, 0, 0));
        wi(4, mk(0, 5'd10, 8'h01, 0, 0));
        wi(5, mk(0, 5'd10, 8'h02, 0, 0));
        wi(6, mk(0, 5'd10, 8'h03, 0, 0));
        // loop program
        wi(8,  mk(0, 5'd12, 8'd16, 0, 0));
        wi(9,  mk(0, 5'd6, 8'd3, 0, 0));
        wi(10, mk(1, 5'd18, 8'd1, 8'hFF, 0));
        wi(11, mk(0, 5'd7, 0, 0, 8'hFE));
        wi(12, mk(0, 5'd10, 8'h21, 0, 0));
        // register program
        wi(20, mk(2, 5'd4, 8'h0F, 0, 0));
        wi(21, mk(2, 5'd3, 8'h30, 8'h03, 0));
        wi(22, mk(2, 5'd3, 8'h40, 8'h40, 0));
        wi(23, mk(0, 5'd4, 8'h96, 0, 0));
        wi(24, mk(1, 5'd4, 8'h00, 0, 0));
        wi(25, mk(2, 5'd2, 8'hF0, 0, 8'd4));
        wi(26, mk(0, 5'd2, 8'hFF, 0, 8'd5));
        wi(27, mk(3, 5'd4, 8'h00, 0, 0));
        wi(28, mk(0, 5'd10, 8'h33, 0, 0));
        // call programs
        wi(30, mk(0, 5'd16, 8'd40, 0, 0));
        wi(31, mk(0, 5'd4, 8'h77, 0, 0));
        wi(32, mk(0, 5'd10, 8'h44, 0, 0));
        wi(34, mk(0, 5'd16, 8'd42, 0, 0));
        wi(35, mk(0, 5'd10, 8'h45, 0, 0));
        wi(36, mk(0, 5'd15, 0, 0, 0));
        wi(40, mk(2, 5'd4, 8'h81, 0, 0));
        wi(41, mk(0, 5'd15, 0, 0, 0));
        wi(42, mk(0, 5'd16, 8'd40, 0, 0));
        // block program
        wi(44, mk(2, 5'd4, 8'h5C, 0, 0));
        wi(45, mk(0, 5'd12, 8'd8, 0, 0));
        wi(46, mk(0, 5'd17, 8'd3, 0, 0));
        wi(47, mk(2, 5'd18, 8'd2, 8'h0F, 0));
        wi(48, mk(2, 5'd18, 8'd0, 8'hFF, 0));
        wi(49, mk(2, 5'd18, 8'd1, 8'hFF, 0));
        wi(50, mk(0, 5'd10, 8'h55, 0, 0));
        // trigger, delay, illegal, lone return
        wi(52, mk(0, 5'd12, 8'd24, 0, 0));
        wi(53, mk(0, 5'd19, 8'd2, 0, 0));
        wi(54, mk(0, 5'd10, 8'h66, 0, 0));
        wi(56, mk(0, 5'd5, 8'd0, 8'd3, 0));
        wi(57, mk(0, 5'd10, 8'h77, 0, 0));
        wi(58, mk(0, 5'd11, 0, 0, 0));
        wi(59, mk(0, 5'd25, 0, 0, 0));
        wi(60, mk(0, 5'd13, 0, 0, 0));
        wi(61, mk(0, 5'd4, 8'hEE, 0, 0));
        wi(62, mk(0, 5'd10, 8'h99, 0, 0));
        wi(63, mk(0, 5'd10, 8'h99, 0, 0));

        // R2 / R10: lone return
        run(63, lat);
        chk("R2 lone RET latency", lat, 2);
        chk("R10 done", done, 1);
        chk("R10 ret code", ret_code, 8'h99);
        repeat (5) @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R10 code held", ret_code, 8'h99);

        // R7 / R8: table of status patterns
        for (int i = 0; i < NVEC; i++) begin
            pp_status_i = VEC[i][15:8];
            run(0, lat);
            chk($sformatf("R7 R8 status %0h", VEC[i][15:8]), ret_code, {24'h0, VEC[i][7:0]});
        end

        // R6: counted loop
        for (int k = 16; k < 20; k++) ws(k, 8'hA5);
        pp_status_i = 8'h5A;
        run(8, lat);
        chk("R6 loop ret", ret_code, 8'h21);
        for (int k = 16; k < 19; k++) begin
            rs(k, rb);
            chk("R6 loop body byte", rb, 8'h5A);
        end
        rs(19, rb);
        chk("R6 no extra pass", rb, 8'hA5);
        wi(9, mk(0, 5'd6, 8'd0, 0, 0));
        ws(16, 8'hA5); ws(17, 8'hA5);
        pp_status_i = 8'h3C;
        run(8, lat);
        rs(16, rb);
        chk("R6 zero count single pass", rb, 8'h3C);
        rs(17, rb);
        chk("R6 zero count no second pass", rb, 8'hA5);

        // R3 / R4 / R5: register operations
        pp_data_i = 8'h3E;
        run(20, lat);
        chk("R4 RSET result", pp_ctrl_o, 8'h3C);
        chk("R3 data after ignored writes", pp_data_o, 8'h96);
        rs(4, rb);
        chk("R5 fetch control", rb, 8'h30);
        rs(5, rb);
        chk("R5 fetch data lines", rb, 8'h3E);

        // R11: call and return
        run(30, lat);
        chk("R11 call ret", ret_code, 8'h44);
        chk("R11 sub body", pp_ctrl_o, 8'h81);
        chk("R11 after return", pp_data_o, 8'h77);
        run(34, lat);
        chk("R11 nested call err", err, 1);
        chk("R11 nested call not done", done, 0);
        run(36, lat);
        chk("R11 stray SUBRET err", err, 1);

        // R12: illegal opcodes
        run(58, lat);
        chk("R12 opcode 11", err, 1);
        run(59, lat);
        chk("R12 opcode 25", err, 1);
        run(60, lat);
        chk("R12 opcode 13", err, 1);
        repeat (5) @(negedge clk);
        chk("R12 halted", busy, 0);
        chk("R12 no later write", pp_data_o, 8'h77);

        // R13: block moves
        ws(8, 8'h11); ws(9, 8'h22); ws(10, 8'h33);
        ws(13, 8'hEE); ws(14, 8'hEE);
        run(44, lat);
        chk("R13 ret", ret_code, 8'h55);
        chk("R13 last byte out", pp_data_o, 8'h33);
        rs(11, rb);
        chk("R13 fetch 1", rb, 8'h0C);
        rs(12, rb);
        chk("R13 fetch 2", rb, 8'h0C);
        rs(13, rb);
        chk("R13 zero count keeps pointer", rb, 8'h5C);
        rs(14, rb);
        chk("R13 no overrun", rb, 8'hEE);

        // R14: trigger pairs
        ws(24, 8'hA1); ws(25, 8'd2); ws(26, 8'hB2); ws(27, 8'd0);
        run(52, lat);
        chk("R14 latency", lat, 2 + 1 + 14);
        chk("R14 final value", pp_data_o, 8'hB2);

        // R9: delay
        run(56, lat);
        chk("R9 latency", lat, 2 + 3 * DIV + 2);
        chk("R9 ret", ret_code, 8'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule